// File: doc/BRIEF.md
# Index-Based Syndrome Encoder/Decoder

This block is the first error-correction stage behind a soft-decision oscillator-sum PUF. It handles one 63-bit code block at a time. The block does not distinguish between data bits and parity bits. Every code bit receives its own group of 16 signed soft responses. Each soft response is the top-minus-bottom delay difference for one candidate.

In enrolment mode, the block scans each group for the strongest representation of the bit to be hidden. For a 1 it takes the largest signed value, and for a 0 it takes the smallest. It writes the 4-bit position of that value to an external helper-data register file, one entry per code bit.

In recovery mode, the same 16 candidates per bit are streamed again. For each bit, the block reads the stored position from the helper file and keeps the sign of the candidate at that position. After the last bit it presents all 63 recovered bits at once, with a one-cycle valid strobe, to the second correction stage.

Soft values arrive on a valid/ready stream. The block accepts at most one value per clock, and only while a block is in progress. A block is started with a one-cycle start pulse that captures the mode and, for enrolment, the 63 bits to encode.

Top module: `ibs_codec`

## Requirements
- R1: After reset and whenever no block is in progress, soft_ready_o, done_o and dec_valid_o are 0. After reset, dec_bits_o is all zeros.
- R2: In enrolment, for a code bit of value 1, the stored index is the position (0..15, in arrival order) of the largest candidate. If several candidates share that value, the lowest position is stored.
- R3: In enrolment, for a code bit of value 0, the stored index is the lowest position holding the smallest candidate.
- R4: Candidates are compared as 8-bit two's complement numbers, so 8'h80 (-128) ranks below 8'h7F (+127).
- R5: In enrolment, exactly 63 helper writes occur per block. Each write happens in the cycle that accepts the 16th candidate of bit i, with hd_addr_o = i and hd_wdata_o the chosen index. Recovery makes no helper writes.
- R6: In recovery, bit i of dec_bits_o is 1 when the candidate at position hd_rdata_i (read at hd_addr_o = i) is strictly positive. It is 0 when that candidate is zero or negative.
- R7: done_o pulses for one cycle, in the cycle after the transfer that carries the 16th candidate of bit 62. dec_valid_o pulses in that same cycle only in recovery mode. dec_bits_o changes only on a dec_valid_o pulse.
- R8: A candidate is consumed only on a cycle with soft_valid_i and soft_ready_o both high. Cycles without valid do not advance the block.
- R9: start_i is ignored while a block is in progress. When a block starts, mode_i (0 = enrolment, 1 = recovery) and enc_bits_i (bit i encodes code bit i) are captured.
- R10: Enrolling a block whose candidates include both signs, then recovering with the same candidates, returns the enrolled bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a block (ignored while busy) |
| mode_i | input | 1 | 0 = enrolment, 1 = recovery |
| enc_bits_i | input | 63 | Code bits to hide, captured on start |
| soft_valid_i | input | 1 | Soft value present |
| soft_ready_o | output | 1 | Block accepts a soft value |
| soft_data_i | input | 8 | Signed soft response |
| hd_we_o | output | 1 | Helper-file write strobe |
| hd_addr_o | output | 6 | Helper-file entry (current code bit) |
| hd_wdata_o | output | 4 | Index to store |
| hd_rdata_i | input | 4 | Stored index at hd_addr_o (combinational read) |
| done_o | output | 1 | Block finished pulse |
| dec_valid_o | output | 1 | Recovered word valid pulse |
| dec_bits_o | output | 63 | Recovered code bits |

## Verification
Most internal errors here surface at the ports within one candidate group. Consider a corrupted running extreme, a wrong tie rule or an unsigned comparison. Each of these stores a wrong index on the write that closes the group, which is at most 16 accepted transfers after the fault. A slipped candidate or bit counter shifts the write address or moves the done pulse. The bench times that pulse to the exact transfer. In recovery, a fault in the capture logic stays hidden until the whole word is presented at the end of the block. That word is compared bit by bit against signs computed independently from the stored indices.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
   typedef enum logic {
      IBS_ENROLL  = 1'b0,
      IBS_RECOVER = 1'b1
   } ibs_mode_e;
endpackage

// File: rtl/ibs_stream_ctr.sv
module ibs_stream_ctr #(
   parameter int NCAND = 16,
   parameter int NBITS = 63,
   localparam int IDX_W  = $clog2(NCAND),
   localparam int ADDR_W = $clog2(NBITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              accept_i,
   output logic              active_o,
   output logic [IDX_W-1:0]  cand_o,
   output logic [ADDR_W-1:0] bit_o,
   output logic              last_cand_o,
   output logic              block_end_o,
   output logic              done_o
);
   logic              active_q;
   logic [IDX_W-1:0]  cand_q;
   logic [ADDR_W-1:0] bit_q;
   logic              last_bit;

   assign last_cand_o = (cand_q == IDX_W'(NCAND - 1));
   assign last_bit    = (bit_q == ADDR_W'(NBITS - 1));
   assign block_end_o = accept_i && last_cand_o && last_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cand_q   <= '0;
         bit_q    <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= block_end_o;
         if (!active_q) begin
            if (start_i) begin
               active_q <= 1'b1;
               cand_q   <= '0;
               bit_q    <= '0;
            end
         end else if (accept_i) begin
            if (last_cand_o) begin
               cand_q <= '0;
               if (last_bit) active_q <= 1'b0;
               else          bit_q    <= bit_q + ADDR_W'(1);
            end else begin
               cand_q <= cand_q + IDX_W'(1);
            end
         end
      end
   end

   assign active_o = active_q;
   assign cand_o   = cand_q;
   assign bit_o    = bit_q;
endmodule

// File: rtl/ibs_extreme_track.sv
module ibs_extreme_track #(
   parameter int SOFT_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     accept_i,
   input  logic                     first_i,
   input  logic                     want_max_i,
   input  logic signed [SOFT_W-1:0] value_i,
   input  logic [IDX_W-1:0]         cand_i,
   output logic [IDX_W-1:0]         win_idx_o
);
   logic signed [SOFT_W-1:0] best_q;
   logic [IDX_W-1:0]         best_idx_q;
   logic                     better;
   logic                     take;

   // strict comparison keeps the earliest position on equal values
   assign better    = want_max_i ? (value_i > best_q) : (value_i < best_q);
   assign take      = first_i || better;
   assign win_idx_o = take ? cand_i : best_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         best_q     <= '0;
         best_idx_q <= '0;
      end else if (accept_i && take) begin
         best_q     <= value_i;
         best_idx_q <= cand_i;
      end
   end
endmodule

// File: rtl/ibs_sign_capture.sv
module ibs_sign_capture #(
   parameter int SOFT_W = 8,
   parameter int IDX_W  = 4,
   parameter int NBITS  = 63,
   localparam int ADDR_W = $clog2(NBITS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable_i,
   input  logic                     accept_i,
   input  logic [ADDR_W-1:0]        bit_i,
   input  logic [IDX_W-1:0]         cand_i,
   input  logic [IDX_W-1:0]         sel_idx_i,
   input  logic signed [SOFT_W-1:0] value_i,
   input  logic                     block_end_i,
   output logic [NBITS-1:0]         bits_o,
   output logic                     valid_o
);
   logic [NBITS-1:0] work_q;
   logic [NBITS-1:0] work_nxt;
   logic             pick;
   logic             positive;

   assign pick     = enable_i && accept_i && (cand_i == sel_idx_i);
   assign positive = (value_i > 0);

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      assign work_nxt[i] = (pick && (bit_i == ADDR_W'(i))) ? positive : work_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         work_q  <= '0;
         bits_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         work_q  <= work_nxt;
         valid_o <= block_end_i && enable_i;
         if (block_end_i && enable_i) bits_o <= work_nxt;
      end
   end
endmodule

// File: rtl/ibs_codec.sv
module ibs_codec #(
   parameter int SOFT_W = 8,
   parameter int IDX_W  = 4,
   parameter int NBITS  = 63,
   localparam int NCAND  = 1 << IDX_W,
   localparam int ADDR_W = $clog2(NBITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic [NBITS-1:0]  enc_bits_i,
   input  logic              soft_valid_i,
   output logic              soft_ready_o,
   input  logic [SOFT_W-1:0] soft_data_i,
   output logic              hd_we_o,
   output logic [ADDR_W-1:0] hd_addr_o,
   output logic [IDX_W-1:0]  hd_wdata_o,
   input  logic [IDX_W-1:0]  hd_rdata_i,
   output logic              done_o,
   output logic              dec_valid_o,
   output logic [NBITS-1:0]  dec_bits_o
);
   import ibs_pkg::*;

   if (SOFT_W < 2) begin : g_bad_soft
      $error("SOFT_W must be at least 2");
   end
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("IDX_W must lie in 1..8");
   end
   if (NBITS < 2) begin : g_bad_nbits
      $error("NBITS must be at least 2");
   end

   ibs_mode_e                mode_q;
   logic [NBITS-1:0]         enc_q;
   logic                     active;
   logic                     accept;
   logic [IDX_W-1:0]         cand;
   logic [ADDR_W-1:0]        bit_idx;
   logic                     last_cand;
   logic                     block_end;
   logic [IDX_W-1:0]         win_idx;
   logic signed [SOFT_W-1:0] soft_s;

   assign soft_s       = $signed(soft_data_i);
   assign soft_ready_o = active;
   assign accept       = active && soft_valid_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= IBS_ENROLL;
         enc_q  <= '0;
      end else if (start_i && !active) begin
         mode_q <= ibs_mode_e'(mode_i);
         enc_q  <= enc_bits_i;
      end
   end

   ibs_stream_ctr #(.NCAND(NCAND), .NBITS(NBITS)) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .accept_i    (accept),
      .active_o    (active),
      .cand_o      (cand),
      .bit_o       (bit_idx),
      .last_cand_o (last_cand),
      .block_end_o (block_end),
      .done_o      (done_o)
   );

   ibs_extreme_track #(.SOFT_W(SOFT_W), .IDX_W(IDX_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .first_i    (cand == '0),
      .want_max_i (enc_q[bit_idx]),
      .value_i    (soft_s),
      .cand_i     (cand),
      .win_idx_o  (win_idx)
   );

   ibs_sign_capture #(.SOFT_W(SOFT_W), .IDX_W(IDX_W), .NBITS(NBITS)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_i    (mode_q == IBS_RECOVER),
      .accept_i    (accept),
      .bit_i       (bit_idx),
      .cand_i      (cand),
      .sel_idx_i   (hd_rdata_i),
      .value_i     (soft_s),
      .block_end_i (block_end),
      .bits_o      (dec_bits_o),
      .valid_o     (dec_valid_o)
   );

   assign hd_addr_o  = bit_idx;
   assign hd_wdata_o = win_idx;
   assign hd_we_o    = accept && last_cand && (mode_q == IBS_ENROLL);
endmodule

// File: rtl/ibs_codec_chk.sv
module ibs_codec_chk #(
   parameter int SOFT_W = 8,
   parameter int IDX_W  = 4,
   parameter int NBITS  = 63,
   localparam int ADDR_W = $clog2(NBITS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              soft_valid_i,
   input logic              soft_ready_o,
   input logic              hd_we_o,
   input logic [ADDR_W-1:0] hd_addr_o,
   input logic              done_o,
   input logic              dec_valid_o,
   input logic [NBITS-1:0]  dec_bits_o
);
   logic [ADDR_W:0] wr_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)       wr_cnt <= '0;
      else if (done_o)  wr_cnt <= '0;
      else if (hd_we_o) wr_cnt <= wr_cnt + 1'b1;
   end

   // R5
   write_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hd_we_o |-> (soft_ready_o && soft_valid_i));

   // R5
   write_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hd_we_o |-> (wr_cnt < (ADDR_W+1)'(NBITS)));

   // R5
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_ready_o |-> (hd_addr_o < ADDR_W'(NBITS)));

   // R7
   valid_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_o |-> done_o);

   // R7
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid_o |-> $stable(dec_bits_o));

   // R1
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !soft_ready_o);

   // R9
   start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_ready_o) |-> $past(start_i));
endmodule

bind ibs_codec ibs_codec_chk #(.SOFT_W(SOFT_W), .IDX_W(IDX_W), .NBITS(NBITS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .soft_valid_i (soft_valid_i),
   .soft_ready_o (soft_ready_o),
   .hd_we_o      (hd_we_o),
   .hd_addr_o    (hd_addr_o),
   .done_o       (done_o),
   .dec_valid_o  (dec_valid_o),
   .dec_bits_o   (dec_bits_o)
);

// File: tb/ibs_codec_tb.sv
module ibs_codec_tb;
   localparam int NB = 63;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          mode_i = 1'b0;
   logic [NB-1:0] enc_bits_i = '0;
   logic          soft_valid_i = 1'b0;
   logic          soft_ready_o;
   logic [7:0]    soft_data_i = '0;
   logic          hd_we_o;
   logic [5:0]    hd_addr_o;
   logic [3:0]    hd_wdata_o;
   logic [3:0]    hd_rdata_i;
   logic          done_o;
   logic          dec_valid_o;
   logic [NB-1:0] dec_bits_o;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   int dv_cnt = 0;
   int wr_cnt = 0;
   int wr_order_bad = 0;
   bit finished = 0;
   logic [3:0] mem [0:63];

   always #2 clk = ~clk;

   ibs_codec u_dut (.*);

   assign hd_rdata_i = mem[hd_addr_o];

   always @(posedge clk) begin
      if (hd_we_o) begin
         mem[hd_addr_o] <= hd_wdata_o;
         if (int'(hd_addr_o) != wr_cnt) wr_order_bad++;
         wr_cnt++;
      end
      if (done_o) done_cnt++;
      if (dec_valid_o) dv_cnt++;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic signed [7:0] gen(int kind, int b, int c, int seed);
      int x;
      logic [7:0] mag;
      x = b * 131 + c * 29 + seed * 977 + 7;
      x = x ^ (x >>> 3);
      x = x * 1103515245 + 12345;
      case (kind)
         1: return 8'sd42;
         2: begin
            if (c == 3) return -8'sd128;
            if (c == 7 || c == 12) return 8'sd127;
            return $signed({4'b0, x[11:8]});
         end
         3: begin
            mag = {1'b0, x[14:8]} | 8'd1;
            return (c % 2 == 0) ? $signed(mag) : -$signed(mag);
         end
         4: return 8'sd0;
         default: return $signed(x[15:8]);
      endcase
   endfunction

   function automatic int exp_idx(int kind, int b, int seed, bit one);
      logic signed [7:0] best;
      int bi;
      best = gen(kind, b, 0, seed);
      bi = 0;
      for (int c = 1; c < 16; c++) begin
         if (one ? (gen(kind, b, c, seed) > best) : (gen(kind, b, c, seed) < best)) begin
            best = gen(kind, b, c, seed);
            bi = c;
         end
      end
      return bi;
   endfunction

   task automatic run_block(input bit mode, input logic [NB-1:0] bits, input int kind,
                            input int seed, input bit stall, input bit poke);
      done_cnt = 0; dv_cnt = 0; wr_cnt = 0; wr_order_bad = 0;
      @(negedge clk);
      start_i = 1'b1; mode_i = mode; enc_bits_i = bits;
      @(negedge clk);
      start_i = 1'b0;
      for (int b = 0; b < NB; b++) begin
         for (int c = 0; c < 16; c++) begin
            if (stall && c == 5) begin
               soft_valid_i = 1'b0;
               soft_data_i = 8'h80;
               @(negedge clk);
               @(negedge clk);
            end
            soft_valid_i = 1'b1;
            soft_data_i = gen(kind, b, c, seed);
            start_i = 1'b0;
            if (poke && b == 10 && c == 0) begin
               start_i = 1'b1; mode_i = ~mode; enc_bits_i = ~bits;
            end
            if (b == NB-1 && c == 15)
               chk(done_cnt == 0 && !done_o, "R7 no early done", done_cnt, 0);
            @(negedge clk);
         end
      end
      soft_valid_i = 1'b0;
      start_i = 1'b0;
      // sampled one cycle after the transfer carrying the last candidate
      chk(done_o == 1'b1, "R7 done timing", done_o, 1);
      chk(dec_valid_o == mode, "R7 dec_valid per mode", dec_valid_o, mode);
   endtask

   task automatic t_reset;
      chk(soft_ready_o == 0, "R1 ready after reset", soft_ready_o, 0);
      chk(done_o == 0 && dec_valid_o == 0, "R1 strobes after reset", {done_o, dec_valid_o}, 0);
      chk(dec_bits_o == '0, "R1 word after reset", dec_bits_o, 0);
   endtask

   task automatic t_enroll(input logic [NB-1:0] bits, input int kind, input int seed,
                           input bit stall, input bit poke, input string req);
      int bad;
      int first_b;
      run_block(1'b0, bits, kind, seed, stall, poke);
      @(negedge clk);
      chk(wr_cnt == NB, "R5 write count", wr_cnt, NB);
      chk(wr_order_bad == 0, "R5 write addresses", wr_order_bad, 0);
      chk(dv_cnt == 0, "R7 no dec_valid in enrolment", dv_cnt, 0);
      chk(done_cnt == 1, "R7 single done", done_cnt, 1);
      bad = 0; first_b = -1;
      for (int b = 0; b < NB; b++)
         if (int'(mem[b]) != exp_idx(kind, b, seed, bits[b])) begin
            bad++;
            if (first_b < 0) first_b = b;
         end
      if (first_b < 0) first_b = 0;
      chk(bad == 0, req, mem[first_b], exp_idx(kind, first_b, seed, bits[first_b]));
   endtask

   task automatic t_recover(input int kind, input int seed, input bit stall,
                            output logic [NB-1:0] got);
      logic [NB-1:0] exp;
      for (int b = 0; b < NB; b++) exp[b] = gen(kind, b, int'(mem[b]), seed) > 0;
      run_block(1'b1, '0, kind, seed, stall, 1'b0);
      got = dec_bits_o;
      chk(dec_bits_o == exp, "R6 recovered signs", dec_bits_o, exp);
      chk(wr_cnt == 0, "R5 no writes in recovery", wr_cnt, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NB-1:0] w;
      logic [NB-1:0] pat_a;
      logic [NB-1:0] pat_b;
      pat_a = 63'h2A3C_F00F_1234_ABCD;
      pat_b = 63'h7123_4567_89AB_CDEF;
      for (int i = 0; i < 64; i++) mem[i] = 4'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      // R2 R3: mixed values, maximum for ones and minimum for zeros
      t_enroll(pat_a, 0, 1, 1'b0, 1'b0, "R2 R3 chosen index");
      // R2 R3: every candidate equal, lowest position wins
      t_enroll(pat_b, 1, 1, 1'b0, 1'b0, "R2 R3 tie picks lowest");
      // R4: -128 and +127 present
      t_enroll(pat_a, 2, 3, 1'b0, 1'b0, "R4 signed comparison");
      // R8 R9: gaps in valid and a start pulse in mid-block
      t_enroll(~pat_a, 0, 2, 1'b1, 1'b1, "R8 R9 stall and ignored start");
      t_recover(0, 2, 1'b1, w);
      // R6: zero soft values recover as 0
      t_recover(4, 0, 1'b0, w);
      chk(w == '0, "R6 zero is not positive", w, 0);
      // R10 round trip
      t_enroll(pat_b, 3, 5, 1'b0, 1'b0, "R10 enrol for round trip");
      chk(dec_bits_o == '0, "R7 word held across enrolment", dec_bits_o, 0);
      t_recover(3, 5, 1'b0, w);
      chk(w == pat_b, "R10 round trip", w, pat_b);
      repeat (3) @(negedge clk);
      chk(soft_ready_o == 0 && done_o == 0, "R1 idle after blocks", {soft_ready_o, done_o}, 0);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule